// File: doc/BRIEF.md
# Unsigned Flag-Generating ALU

This block is the arithmetic and logic unit of a small 16-bit processor that works on unsigned numbers only. Each cycle the surrounding datapath may present an operation code, two register operands and an 8-bit immediate. The unit computes a 16-bit primary result, a 16-bit secondary result (used only by division, for the remainder) and the next value of a 4-bit condition vector. Register reads, write-back, instruction fetch and sequencing stay with the caller. The caller writes the primary result to the destination register. For division it writes the primary result to register 0 and the secondary result to register 1.

The arithmetic core is purely combinational. A single output stage with a clock enable registers its results, so every result appears on the clock edge that follows the operation's presentation. Subtraction saturates at zero on underflow. Division by zero gives zero for both results. Overflow is reported through the condition vector. Every operation that does not define its own condition behaviour leaves that vector cleared.

Top module: `uflag_alu`

## Requirements
- R1: Code 00000 (add) returns the low 16 bits of src_a + src_b. Flag bit 3 (V) is 1 exactly when the true sum is 65536 or more. Flag bits 2..0 are 0.
- R2: Code 00001 (subtract) returns src_a - src_b with V=0 when src_b <= src_a. When src_b > src_a it returns 0 and sets V. Bits 2..0 are 0.
- R3: Code 00110 (multiply) returns the low 16 bits of src_a * src_b. V is 1 exactly when the true product is 65536 or more. Bits 2..0 are 0.
- R4: Code 00111 (divide) returns the quotient src_a / src_b on res_lo and the remainder on res_hi, with flags 0. A zero divisor returns 0 on both and sets V only.
- R5: Code 01000 shifts src_a right and code 01001 shifts it left, by the unsigned amount imm. Both shifts are logical and fill with zeros. An amount of 16 or more gives 0. Flags are 0.
- R6: Codes 01010, 01011 and 01100 return the bitwise XOR, OR and AND of src_a and src_b. Code 01101 returns the bitwise NOT of src_a. Flags are 0.
- R7: Code 01110 (compare) sets exactly one flag: bit 2 (L) if src_a < src_b, bit 1 (G) if src_a > src_b, bit 0 (E) if they are equal. V is 0, and res_lo and res_hi are 0.
- R8: res_hi is 0 for every operation except divide. Any code not listed in R1 to R7 returns res_lo = 0, res_hi = 0 and flags = 0. A compare result is therefore cleared by the next operation that does not set flags.
- R9: res_valid and the results of an operation appear on the first rising clock edge at which op_valid is sampled high. While op_valid is low, res_valid is 0 and res_lo, res_hi and flags keep their values.
- R10: While rst_n is low, res_valid, res_lo, res_hi and flags are 0. They clear asynchronously. Operations are accepted from the third rising edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code |
| src_a | input | 16 | First operand |
| src_b | input | 16 | Second operand |
| imm | input | 8 | Shift amount |
| res_valid | output | 1 | Results updated by the last edge |
| res_lo | output | 16 | Primary result or quotient |
| res_hi | output | 16 | Remainder for divide, else 0 |
| flags | output | 4 | Condition vector {V, L, G, E} |

## Verification
Every result is due exactly one rising edge after an operation is presented: res_lo, res_hi, flags and res_valid all come from the same output register. The bench drives each operation on a falling edge and samples on the next falling edge. That places the sample after exactly one rising edge, with half a cycle of margin on both sides. The hold check leaves op_valid low for two edges before it samples. The reset checks sample shortly after rst_n falls, with no clock edge in between, and wait out the two-edge release synchroniser before sending new operations.

// File: rtl/ualu_pkg.sv
package ualu_pkg;

  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_ADD = 5'b00000;
  localparam logic [OPC_W-1:0] OPC_SUB = 5'b00001;
  localparam logic [OPC_W-1:0] OPC_MUL = 5'b00110;
  localparam logic [OPC_W-1:0] OPC_DIV = 5'b00111;
  localparam logic [OPC_W-1:0] OPC_SHR = 5'b01000;
  localparam logic [OPC_W-1:0] OPC_SHL = 5'b01001;
  localparam logic [OPC_W-1:0] OPC_XOR = 5'b01010;
  localparam logic [OPC_W-1:0] OPC_IOR = 5'b01011;
  localparam logic [OPC_W-1:0] OPC_AND = 5'b01100;
  localparam logic [OPC_W-1:0] OPC_INV = 5'b01101;
  localparam logic [OPC_W-1:0] OPC_CMP = 5'b01110;

  // condition vector, most significant first: overflow, less, greater, equal
  typedef struct packed {
    logic ovf;
    logic lt;
    logic gt;
    logic eq;
  } cond_t;

  localparam cond_t COND_CLEAR = '{ovf: 1'b0, lt: 1'b0, gt: 1'b0, eq: 1'b0};

endpackage

// File: rtl/ualu_arith.sv
module ualu_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         sum_ovf,
  output logic [W-1:0] diff,
  output logic         diff_ovf,
  output logic [W-1:0] prod,
  output logic         prod_ovf,
  output logic         a_lt,
  output logic         a_gt,
  output logic         a_eq
);

  localparam int PW = 2 * W;

  logic [W:0]    sum_full;
  logic [PW-1:0] prod_full;

  always_comb begin
    sum_full  = {1'b0, a} + {1'b0, b};
    prod_full = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    sum      = sum_full[W-1:0];
    sum_ovf  = sum_full[W];
    prod     = prod_full[W-1:0];
    prod_ovf = |prod_full[PW-1:W];

    a_lt = a < b;
    a_gt = a > b;
    a_eq = a == b;

    diff_ovf = a_lt;
    diff     = a_lt ? '0 : (a - b);
  end

endmodule

// File: rtl/ualu_divider.sv
module ualu_divider #(
  parameter int W = 16
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         div_zero
);

  // restoring division, one unrolled stage per quotient bit
  logic [W:0] part [W+1];

  assign part[0]  = '0;
  assign div_zero = (divisor == '0);

  for (genvar k = 0; k < W; k++) begin : g_stage
    localparam int BIT = W - 1 - k;
    logic [W:0] trial;
    logic       fits;

    assign trial      = {part[k][W-1:0], dividend[BIT]};
    assign fits       = trial >= {1'b0, divisor};
    assign part[k+1]  = fits ? (trial - {1'b0, divisor}) : trial;
    assign quo[BIT]   = fits;
  end

  assign rem = part[W][W-1:0];

endmodule

// File: rtl/ualu_bitops.sv
module ualu_bitops #(
  parameter int W     = 16,
  parameter int SHW   = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   shr,
  output logic [W-1:0]   shl,
  output logic [W-1:0]   bxor,
  output logic [W-1:0]   bor,
  output logic [W-1:0]   band,
  output logic [W-1:0]   binv
);

  logic [31:0] amt32;
  logic        too_far;

  always_comb begin
    amt32   = 32'(amt);
    too_far = amt32 >= 32'(W);
    shr     = too_far ? '0 : (a >> amt32);
    shl     = too_far ? '0 : (a << amt32);
    bxor    = a ^ b;
    bor     = a | b;
    band    = a & b;
    binv    = ~a;
  end

endmodule

// File: rtl/uflag_alu.sv
module uflag_alu
  import ualu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi,
  output logic [3:0]        flags
);

  localparam int SYNC_N = 2;

  // reset: asserted at once, released through a short flop chain
  logic [SYNC_N-1:0] rst_chain;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain <= '0;
    else        rst_chain <= {rst_chain[SYNC_N-2:0], 1'b1};
  end

  assign rst_sync_n = rst_chain[SYNC_N-1];

  // function units
  logic [DATA_W-1:0] sum, diff, prod, quo, rem;
  logic [DATA_W-1:0] shr, shl, bxor, bor, band, binv;
  logic              sum_ovf, diff_ovf, prod_ovf, div_zero;
  logic              a_lt, a_gt, a_eq;

  ualu_arith #(.W(DATA_W)) u_arith (
    .a(src_a), .b(src_b),
    .sum(sum), .sum_ovf(sum_ovf),
    .diff(diff), .diff_ovf(diff_ovf),
    .prod(prod), .prod_ovf(prod_ovf),
    .a_lt(a_lt), .a_gt(a_gt), .a_eq(a_eq)
  );

  ualu_divider #(.W(DATA_W)) u_div (
    .dividend(src_a), .divisor(src_b),
    .quo(quo), .rem(rem), .div_zero(div_zero)
  );

  ualu_bitops #(.W(DATA_W), .SHW(IMM_W)) u_bits (
    .a(src_a), .b(src_b), .amt(imm),
    .shr(shr), .shl(shl), .bxor(bxor), .bor(bor), .band(band), .binv(binv)
  );

  // next-state selection
  logic [DATA_W-1:0] lo_nxt, hi_nxt;
  cond_t             cond_nxt;

  always_comb begin
    lo_nxt   = '0;
    hi_nxt   = '0;
    cond_nxt = COND_CLEAR;
    unique case (op_code)
      OPC_ADD: begin lo_nxt = sum;  cond_nxt.ovf = sum_ovf;  end
      OPC_SUB: begin lo_nxt = diff; cond_nxt.ovf = diff_ovf; end
      OPC_MUL: begin lo_nxt = prod; cond_nxt.ovf = prod_ovf; end
      OPC_DIV: begin
        if (div_zero) begin
          cond_nxt.ovf = 1'b1;
        end else begin
          lo_nxt = quo;
          hi_nxt = rem;
        end
      end
      OPC_SHR: lo_nxt = shr;
      OPC_SHL: lo_nxt = shl;
      OPC_XOR: lo_nxt = bxor;
      OPC_IOR: lo_nxt = bor;
      OPC_AND: lo_nxt = band;
      OPC_INV: lo_nxt = binv;
      OPC_CMP: begin
        cond_nxt.lt = a_lt;
        cond_nxt.gt = a_gt;
        cond_nxt.eq = a_eq;
      end
      default: ;
    endcase
  end

  // output register with explicit enable
  cond_t cond_q;
  logic  res_en;

  assign res_en = op_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
      cond_q    <= COND_CLEAR;
    end else begin
      res_valid <= res_en;
      if (res_en) begin
        res_lo <= lo_nxt;
        res_hi <= hi_nxt;
        cond_q <= cond_nxt;
      end
    end
  end

  assign flags = cond_q;

endmodule

// File: rtl/ualu_chk.sv
module ualu_chk
  import ualu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [OPC_W-1:0]  op_code,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_lo,
  input logic [DATA_W-1:0] res_hi,
  input logic [3:0]        flags
);

  // R7
  cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags[2:0]));

  // R7
  cmp_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2:0] != 3'b000) |-> (res_lo == '0 && res_hi == '0 && !flags[3]));

  // R2
  sub_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPC_SUB && src_b > src_a) |=> (res_lo == '0 && flags == 4'b1000));

  // R4
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPC_DIV && src_b == '0) |=> (res_lo == '0 && res_hi == '0 && flags == 4'b1000));

  // R4
  div_rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPC_DIV && src_b != '0) |=> (res_hi < $past(src_b) && flags == 4'b0000));

  // R8
  hi_only_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hi != '0) |-> (flags == 4'b0000));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(res_lo) && $stable(res_hi) && $stable(flags)));

  // R9
  issue_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

endmodule

bind uflag_alu ualu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .op_valid(op_valid), .op_code(op_code),
  .src_a(src_a), .src_b(src_b), .res_valid(res_valid),
  .res_lo(res_lo), .res_hi(res_hi), .flags(flags)
);

// File: tb/sim_uflag_alu.sv
`timescale 1ns/1ps
module sim_uflag_alu;

  localparam int NV = 30;
  // {op, a, b, imm, lo, hi, flags, req}
  localparam logic [84:0] VECS [NV] = '{
    {5'b00000, 16'h0003, 16'h0004, 8'd0,   16'h0007, 16'h0000, 4'b0000, 4'd1},  // R1
    {5'b00000, 16'hFFFF, 16'h0002, 8'd0,   16'h0001, 16'h0000, 4'b1000, 4'd1},  // R1
    {5'b00000, 16'h8000, 16'h8000, 8'd0,   16'h0000, 16'h0000, 4'b1000, 4'd1},  // R1
    {5'b00001, 16'h000A, 16'h0003, 8'd0,   16'h0007, 16'h0000, 4'b0000, 4'd2},  // R2
    {5'b00001, 16'h0003, 16'h0004, 8'd0,   16'h0000, 16'h0000, 4'b1000, 4'd2},  // R2
    {5'b00001, 16'h5555, 16'h5555, 8'd0,   16'h0000, 16'h0000, 4'b0000, 4'd2},  // R2
    {5'b00110, 16'h000A, 16'h0064, 8'd0,   16'h03E8, 16'h0000, 4'b0000, 4'd3},  // R3
    {5'b00110, 16'h0100, 16'h0100, 8'd0,   16'h0000, 16'h0000, 4'b1000, 4'd3},  // R3
    {5'b00110, 16'h1234, 16'h0010, 8'd0,   16'h2340, 16'h0000, 4'b1000, 4'd3},  // R3
    {5'b00110, 16'hFFFF, 16'h0001, 8'd0,   16'hFFFF, 16'h0000, 4'b0000, 4'd3},  // R3
    {5'b00111, 16'h0064, 16'h0007, 8'd0,   16'h000E, 16'h0002, 4'b0000, 4'd4},  // R4
    {5'b00111, 16'h0005, 16'h0009, 8'd0,   16'h0000, 16'h0005, 4'b0000, 4'd4},  // R4
    {5'b00111, 16'hFFFF, 16'h0001, 8'd0,   16'hFFFF, 16'h0000, 4'b0000, 4'd4},  // R4
    {5'b00111, 16'h1234, 16'h0000, 8'd0,   16'h0000, 16'h0000, 4'b1000, 4'd4},  // R4
    {5'b01000, 16'hF0F0, 16'h0000, 8'd4,   16'h0F0F, 16'h0000, 4'b0000, 4'd5},  // R5
    {5'b01001, 16'hF0F0, 16'h0000, 8'd4,   16'h0F00, 16'h0000, 4'b0000, 4'd5},  // R5
    {5'b01001, 16'h0001, 16'h0000, 8'd15,  16'h8000, 16'h0000, 4'b0000, 4'd5},  // R5
    {5'b01000, 16'hFFFF, 16'h0000, 8'd16,  16'h0000, 16'h0000, 4'b0000, 4'd5},  // R5
    {5'b01001, 16'hFFFF, 16'h0000, 8'd200, 16'h0000, 16'h0000, 4'b0000, 4'd5},  // R5
    {5'b01010, 16'hF0F0, 16'hFF00, 8'd0,   16'h0FF0, 16'h0000, 4'b0000, 4'd6},  // R6
    {5'b01011, 16'hF0F0, 16'h0F00, 8'd0,   16'hFFF0, 16'h0000, 4'b0000, 4'd6},  // R6
    {5'b01100, 16'hF0F0, 16'hFF00, 8'd0,   16'hF000, 16'h0000, 4'b0000, 4'd6},  // R6
    {5'b01101, 16'h1234, 16'h0000, 8'd0,   16'hEDCB, 16'h0000, 4'b0000, 4'd6},  // R6
    {5'b01110, 16'h0005, 16'h000A, 8'd0,   16'h0000, 16'h0000, 4'b0100, 4'd7},  // R7
    {5'b01110, 16'h000A, 16'h0005, 8'd0,   16'h0000, 16'h0000, 4'b0010, 4'd7},  // R7
    {5'b01110, 16'h0007, 16'h0007, 8'd0,   16'h0000, 16'h0000, 4'b0001, 4'd7},  // R7
    {5'b01110, 16'h0000, 16'hFFFF, 8'd0,   16'h0000, 16'h0000, 4'b0100, 4'd7},  // R7
    {5'b00010, 16'h1234, 16'h5678, 8'd9,   16'h0000, 16'h0000, 4'b0000, 4'd8},  // R8 clears L
    {5'b10011, 16'hFFFF, 16'hFFFF, 8'd1,   16'h0000, 16'h0000, 4'b0000, 4'd8},  // R8
    {5'b11111, 16'hABCD, 16'h0001, 8'd3,   16'h0000, 16'h0000, 4'b0000, 4'd8}   // R8
  };

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [4:0]  op_code;
  logic [15:0] src_a, src_b;
  logic [7:0]  imm;
  logic        res_valid;
  logic [15:0] res_lo, res_hi;
  logic [3:0]  flags;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  uflag_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .imm(imm), .res_valid(res_valid),
    .res_lo(res_lo), .res_hi(res_hi), .flags(flags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input int req, input logic v, input logic [15:0] lo,
                           input logic [15:0] hi, input logic [3:0] fl);
    chk(req, "res_valid", 32'(res_valid), 32'(v));
    chk(req, "res_lo",    32'(res_lo),    32'(lo));
    chk(req, "res_hi",    32'(res_hi),    32'(hi));
    chk(req, "flags",     32'(flags),     32'(fl));
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    // R10: cleared asynchronously, before any edge
    check_all(10, 1'b0, 16'h0, 16'h0, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b1; op_valid = 1'b0; op_code = '0;
    src_a = '0; src_b = '0; imm = '0;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R10: reset state
    check_all(10, 1'b0, 16'h0, 16'h0, 4'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      op_valid = 1'b1;
      {op_code, src_a, src_b, imm} = VECS[i][84:40];
      @(negedge clk);
      check_all(int'(VECS[i][3:0]), 1'b1, VECS[i][39:24], VECS[i][23:8], VECS[i][7:4]);
    end

    // R9: hold while idle (result of a divide kept, inputs changing)
    op_valid = 1'b1; op_code = 5'b00111; src_a = 16'd50; src_b = 16'd8; imm = '0;
    @(negedge clk);
    check_all(9, 1'b1, 16'd6, 16'd2, 4'b0000);
    op_valid = 1'b0; op_code = 5'b00000; src_a = 16'hFFFF; src_b = 16'hFFFF;
    repeat (2) @(negedge clk);
    check_all(9, 1'b0, 16'd6, 16'd2, 4'b0000);

    // R1 with R9: back-to-back after idle, overflow then cleared by xor (R6)
    op_valid = 1'b1;
    @(negedge clk);
    check_all(1, 1'b1, 16'hFFFE, 16'h0, 4'b1000);
    op_code = 5'b01010; src_a = 16'h00FF; src_b = 16'h0F0F;
    @(negedge clk);
    check_all(6, 1'b1, 16'h0FF0, 16'h0, 4'b0000);
    op_valid = 1'b0;

    // R10: reset mid-run, then the unit works again
    apply_reset();
    op_valid = 1'b1; op_code = 5'b01110; src_a = 16'd3; src_b = 16'd3;
    @(negedge clk);
    check_all(10, 1'b1, 16'h0, 16'h0, 4'b0001);
    op_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule